// File: doc/BRIEF.md
# Event interrupt latch with mask set/clear aliases

This block gathers single-cycle event pulses from a serial-peripheral controller into a sticky latch. It combines the latch with a per-event enable mask to drive one interrupt line. Ten event kinds are tracked: receive and transmit watermark crossings, receive overrun, transmit underrun, transmit collision, mode fault, and the start and finish of receive and of transmit. Each kind owns a fixed bit in a 12-bit register image. Bits 0 and 3 of that image are never used.

Software reaches the block through a small register port. The mask can be written whole at one address. Two more addresses change only selected mask bits: a 1 at one address clears the bit, and a 1 at the other sets it. The latch can be read at its own address and cleared bit by bit through a write-one-to-clear address. The mask does not stop an event from being captured. It only decides whether a captured event reaches the interrupt line.

Top module: `evt_irq_latch`

## Requirements
- R1: After reset the mask and the latch are zero, every read returns 0 and `irqOut` is low.
- R2: An event pulse on `eventIn[k]` sets latch bit k at the next clock edge, whatever the mask holds. The positions are: 1 receive watermark, 2 transmit watermark, 4 receive overrun, 5 transmit underrun, 6 transmit collision, 7 mode fault, 8 receive start, 9 transmit start, 10 receive finish, 11 transmit finish.
- R3: Bits 0 and 3 are unused. They are ignored on `eventIn` and on written data, and they always read as 0.
- R4: A write to address 0 loads the mask from the write data. Reading address 0 returns the mask.
- R5: A write to address 1 clears each mask bit whose data bit is 1 and leaves the others unchanged. Reading address 1 returns the mask.
- R6: A write to address 2 sets each mask bit whose data bit is 1 and leaves the others unchanged. Reading address 2 returns the mask.
- R7: Reading address 3 returns the latch. Writes to address 3 have no effect.
- R8: A write to address 4 clears each latch bit whose data bit is 1 and leaves the others unchanged. Reading address 4 returns the latch.
- R9: When an event and a latch-clear write hit the same bit in the same cycle, the bit ends up set.
- R10: `irqOut` is high exactly when some bit is set in both the latch and the mask. It follows register state with no added delay.
- R11: Addresses 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address (read and write) |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 12 | Write data |
| regRdData | output | 12 | Combinational read data for `regAddr` |
| eventIn | input | 12 | One-cycle event pulses in register bit layout |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that event pulses and register writes are sampled only at clock edges. They also assume that `regAddr` is stable through a cycle, so a read in the cycle after a write shows the result of that write. The stimulus changes every input only on the falling edge. It draws address, write enable, data and event bits at random with a fixed seed, and that covers same-cycle clear and event collisions. Directed steps add the unused bits, the unmapped addresses and the read-only latch address.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;
  localparam int REG_W  = 12;
  localparam int ADDR_W = 3;
  // Bits that carry an event; 0 and 3 are holes in the layout.
  localparam logic [REG_W-1:0] EVT_BITS = 12'hFF6;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK      = 3'd0,
    A_MASK_CLR  = 3'd1,
    A_MASK_SET  = 3'd2,
    A_LATCH     = 3'd3,
    A_LATCH_CLR = 3'd4
  } regAddr_e;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_MASK  = 2'd1,
    RD_LATCH = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   maskWr;
    logic   maskClr;
    logic   maskSet;
    logic   latchClr;
    rdSel_e rdSel;
  } ctrlStb_t;
endpackage

// File: rtl/irqlat_ctrl.sv
module irqlat_ctrl
  import irqlat_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStb_t          stb
);
  always_comb begin
    stb = '{maskWr: 1'b0, maskClr: 1'b0, maskSet: 1'b0, latchClr: 1'b0, rdSel: RD_NONE};
    case (regAddr)
      A_MASK: begin
        stb.maskWr = regWrEn;
        stb.rdSel  = RD_MASK;
      end
      A_MASK_CLR: begin
        stb.maskClr = regWrEn;
        stb.rdSel   = RD_MASK;
      end
      A_MASK_SET: begin
        stb.maskSet = regWrEn;
        stb.rdSel   = RD_MASK;
      end
      A_LATCH: stb.rdSel = RD_LATCH;
      A_LATCH_CLR: begin
        stb.latchClr = regWrEn;
        stb.rdSel    = RD_LATCH;
      end
      default: stb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/irqlat_dp.sv
module irqlat_dp
  import irqlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] eventIn,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut
);
  logic [REG_W-1:0] maskQ;
  logic [REG_W-1:0] latchQ;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (EVT_BITS[i]) begin : g_live
      logic maskNext;
      always_comb begin
        if (stb.maskWr)       maskNext = wrData[i];
        else if (stb.maskClr) maskNext = maskQ[i] & ~wrData[i];
        else if (stb.maskSet) maskNext = maskQ[i] | wrData[i];
        else                  maskNext = maskQ[i];
      end
      always_ff @(posedge clk) begin
        if (!rstN) begin
          maskQ[i]  <= 1'b0;
          latchQ[i] <= 1'b0;
        end else begin
          maskQ[i]  <= maskNext;
          // a fresh event outranks a clear in the same cycle
          latchQ[i] <= (latchQ[i] & ~(stb.latchClr & wrData[i])) | eventIn[i];
        end
      end
    end else begin : g_hole
      assign maskQ[i]  = 1'b0;
      assign latchQ[i] = 1'b0;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RD_MASK:  rdData = maskQ;
      RD_LATCH: rdData = latchQ;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = |(maskQ & latchQ);
endmodule

// File: rtl/evt_irq_latch.sv
module evt_irq_latch
  import irqlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [REG_W-1:0]  eventIn,
  output logic              irqOut
);
  ctrlStb_t stb;

  irqlat_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .stb     (stb)
  );

  irqlat_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (regWrData),
    .eventIn (eventIn),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/irqlat_checker.sv
module irqlat_checker
  import irqlat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic [REG_W-1:0]  eventIn,
  input logic              irqOut
);
  // R3: holes never read back as set
  p_holes_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[0] == 1'b0) && (regRdData[3] == 1'b0));

  // R2 and R9: a captured event is visible on the next latch read, even under a clear
  p_event_latched_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|(eventIn & EVT_BITS)) |=>
      ((regAddr != A_LATCH) ||
       ((regRdData & $past(eventIn & EVT_BITS)) == $past(eventIn & EVT_BITS))));

  // R5
  p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_MASK_CLR) |=>
      ((regAddr != A_MASK) || ((regRdData & $past(regWrData)) == '0)));

  // R6
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_MASK_SET) |=>
      ((regAddr != A_MASK) ||
       ((regRdData & $past(regWrData & EVT_BITS)) == $past(regWrData & EVT_BITS))));

  // R7: with no event, the latch holds across a cycle (writes at this address included)
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_LATCH && (eventIn & EVT_BITS) == '0) |=>
      ((regAddr != A_LATCH) || $stable(regRdData)));

  // R10: an interrupt implies a latched bit when the latch is visible
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && regAddr == A_LATCH) |-> (regRdData != '0));
endmodule

bind evt_irq_latch irqlat_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .eventIn   (eventIn),
  .irqOut    (irqOut)
);

// File: tb/evt_irq_latch_bench.sv
`timescale 1ns/1ps
module evt_irq_latch_bench;
  localparam logic [11:0] LIVE = 12'hFF6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [11:0] regWrData = '0;
  logic [11:0] regRdData;
  logic [11:0] eventIn = '0;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  logic [11:0] mM = '0;
  logic [11:0] lM = '0;

  always #2 clk = ~clk;

  evt_irq_latch u_evt_irq_latch (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .eventIn(eventIn), .irqOut(irqOut)
  );

  function automatic logic [11:0] expRead(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2: return mM;
      3'd3, 3'd4:       return lM;
      default:          return '0;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check12(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, advance the model at the rising edge, sample 1 ns later.
  task automatic step(input logic [2:0] a, input logic w, input logic [11:0] d,
                      input logic [11:0] e, input string tag);
    @(negedge clk);
    regAddr = a; regWrEn = w; regWrData = d; eventIn = e;
    @(posedge clk);
    if (w) begin
      case (a)
        3'd0: mM = d & LIVE;
        3'd1: mM = mM & ~d;
        3'd2: mM = mM | (d & LIVE);
        3'd4: lM = lM & ~d;
        default: ;
      endcase
    end
    lM = lM | (e & LIVE);
    #1;
    check12(tag, regRdData, expRead(a));
    check1("R10", irqOut, |(mM & lM));
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0bad));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check12("R1", regRdData, 12'h000);
    check1("R1", irqOut, 1'b0);
    step(3'd3, 1'b0, '0, '0, "R1");
    // R2: events latch with mask clear, no interrupt
    step(3'd3, 1'b0, '0, 12'h802, "R2");
    check12("R2", regRdData, 12'h802);
    check1("R2", irqOut, 1'b0);
    // R3: holes ignored on events and on writes
    step(3'd3, 1'b0, '0, 12'h009, "R3");
    step(3'd0, 1'b1, 12'hFFF, '0, "R3");
    check12("R3", regRdData, 12'hFF6);
    // R5: clear alias drops selected mask bits
    step(3'd1, 1'b1, 12'hFFD, '0, "R5");
    step(3'd0, 1'b0, '0, '0, "R5");
    check12("R5", regRdData, 12'h002);
    check1("R10", irqOut, 1'b1);
    // R6: set alias
    step(3'd1, 1'b1, 12'hFFF, '0, "R5");
    check1("R10", irqOut, 1'b0);
    step(3'd2, 1'b1, 12'h800, '0, "R6");
    check12("R6", regRdData, 12'h800);
    check1("R10", irqOut, 1'b1);
    // R7: write to latch address ignored
    step(3'd3, 1'b1, 12'h000, '0, "R7");
    check12("R7", regRdData, 12'h802);
    // R9: clear and event on the same bit
    step(3'd4, 1'b1, 12'hFFF, 12'h800, "R9");
    check12("R9", regRdData, 12'h800);
    // R8: plain clear
    step(3'd4, 1'b1, 12'h800, '0, "R8");
    check12("R8", regRdData, 12'h000);
    check1("R10", irqOut, 1'b0);
    // R11: unmapped address
    step(3'd6, 1'b1, 12'hFFF, '0, "R11");
    step(3'd0, 1'b0, '0, '0, "R11");
    check12("R11", regRdData, 12'h800);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  a;
      logic [11:0] d, e;
      a = 3'($urandom_range(0, 7));
      d = 12'($urandom);
      e = 12'($urandom & $urandom & $urandom);
      step(a, 1'($urandom), d, e, tagFor(a));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule